// File: doc/BRIEF.md
# Buck Gate Drive Sequencer

This block sequences the two gate enables of a synchronous buck power stage from a clocked, digital view of the controller's commands. A pre-decoded three-level PWM command (high, low or floating) and a two-bit conduction mode (shutdown, continuous or discontinuous) select which switch conducts. A zero-current comparator flag and an undervoltage flag arrive as single-bit inputs. Every delay is a whole number of clock cycles and is set by a parameter. The defaults assume a 1 GHz clock: a 150-cycle floating hold-off, a 45-cycle floating exit delay, 15 and 13 cycles of dead time, and a 350-cycle low-side minimum on-time.

A floating-input filter is a two-state machine. In FS_TRACK it follows valid PWM levels and counts floating cycles. It moves to FS_FLOAT once the input has floated for the hold-off. It returns to FS_TRACK only after the input has been valid for the exit delay. The gate sequencer is a six-state machine:
- GS_OFF: both gates off.
- GS_DT_HS: dead time before the high side turns on.
- GS_HS: high side on.
- GS_DT_LS: dead time before the low side turns on.
- GS_LS: low side on, with its minimum on-time counted.
- GS_LS_IDLE: discontinuous-mode rest after a zero-current turn-off, both gates off.

Any halt condition (undervoltage, a filtered floating PWM, or a shutdown mode) sends the sequencer to GS_OFF. It leaves GS_OFF as follows:
- PWM high: to GS_DT_HS.
- PWM low in continuous mode: to GS_DT_LS.
- PWM low in discontinuous mode: to GS_LS_IDLE.

GS_DT_HS moves to GS_HS when its count expires. GS_DT_LS moves to GS_LS when its count expires. A level change from either dead-time state goes to the opposite dead-time state. GS_HS goes to GS_DT_LS when PWM is low. GS_LS goes to GS_DT_HS when PWM is high. GS_LS goes to GS_LS_IDLE on zero current in discontinuous mode, once the minimum on-time is complete. GS_LS_IDLE goes to GS_DT_HS when PWM is high, and to GS_DT_LS in continuous mode.

Top module: `buck_gate_seq`

## Requirements
- R1: During and after reset both gates are off. A valid PWM level applied after reset drives no gate until it has been held for EXIT_CYC clock edges, followed by the dead time.
- R2: With PWM high (pwm_cmd = 2'b01) in continuous (mode_sel = 2'b01) or discontinuous (mode_sel = 2'b10) mode, hs_on is 1 and ls_on is 0.
- R3: With PWM low (pwm_cmd = 2'b00) in continuous mode, hs_on is 0 and ls_on is 1.
- R4: After PWM goes low, hs_on drops at the first edge that acts on the change. ls_on rises DT_LS_CYC edges later. When PWM goes high, the same holds with DT_HS_CYC and the roles swapped. hs_on and ls_on are never 1 in the same cycle.
- R5: A floating PWM (pwm_cmd[1] = 1) held for HOLD_CYC edges turns both gates off from edge HOLD_CYC+1, counted from the first edge that samples it.
- R6: A floating PWM lasting fewer than HOLD_CYC edges leaves the gate outputs unchanged.
- R7: After a filtered float, a valid low PWM in continuous mode turns ls_on on at edge EXIT_CYC+1+DT_LS_CYC, counted from the first valid sample. Both gates stay off before that edge.
- R8: In discontinuous mode the low side stays on for at least MIN_ON_CYC cycles. A zero-current flag during that window has no effect. A flag still present, or first seen, after the window turns the low side off one edge after it is sampled.
- R9: After a zero-current turn-off in discontinuous mode, both gates stay off while PWM is low. PWM going high restarts the high side after DT_HS_CYC.
- R10: In continuous mode zc_flag has no effect; ls_on follows the inverse of PWM.
- R11: uv_flag high turns both gates off at the next edge. When it clears with PWM high, hs_on returns DT_HS_CYC+1 edges later.
- R12: mode_sel 2'b00 and 2'b11 are both shutdown: both gates off at the next edge. Return to continuous mode with PWM high restores hs_on DT_HS_CYC+1 edges later.
- R13: Entering discontinuous mode from shutdown with PWM low keeps both gates off until PWM goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_cmd | input | 2 | Decoded PWM: 00 low, 01 high, 1x floating |
| mode_sel | input | 2 | 00/11 shutdown, 01 continuous, 10 discontinuous |
| zc_flag | input | 1 | Inductor current has reached zero |
| uv_flag | input | 1 | Gate supply below lockout level |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The gate enables are decoded straight from the sequencer state, so a wrong state shows at the ports on the next clock edge. A sequencer that skipped a dead-time state would show an early rising enable. A stuck minimum-on count would show a low-side pulse of the wrong length. A filter that miscounts moves the turn-off edge of a floating PWM by a cycle, or reacts to a short glitch. The bench sweeps the glitch length across the whole hold-off window and the zero-current arrival time across the whole minimum on-time window. Each of these errors therefore appears as a cycle-exact mismatch.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

    typedef enum logic [1:0] {
        MD_SD_A = 2'b00,
        MD_CCM  = 2'b01,
        MD_DCM  = 2'b10,
        MD_SD_B = 2'b11
    } mode_e;

    typedef enum logic {
        FS_TRACK = 1'b0,
        FS_FLOAT = 1'b1
    } filt_state_e;

    typedef enum logic [2:0] {
        GS_OFF     = 3'd0,
        GS_DT_HS   = 3'd1,
        GS_HS      = 3'd2,
        GS_DT_LS   = 3'd3,
        GS_LS      = 3'd4,
        GS_LS_IDLE = 3'd5
    } gate_state_e;

endpackage

// File: rtl/bgs_float_filter.sv
module bgs_float_filter
    import buck_gate_pkg::*;
#(
    parameter int HOLD_CYC = 150,
    parameter int EXIT_CYC = 45
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_cmd,
    output logic       lvl_q,
    output logic       flt_q
);
    localparam int CMAX = (HOLD_CYC > EXIT_CYC) ? HOLD_CYC : EXIT_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    filt_state_e    fs_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  cnt_inc;
    logic           in_float;

    assign in_float = pwm_cmd[1];
    assign cnt_inc  = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= FS_FLOAT;
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            unique case (fs_q)
                FS_TRACK: begin
                    if (in_float) begin
                        if (cnt_inc == CW'(HOLD_CYC)) begin
                            fs_q  <= FS_FLOAT;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_inc;
                        end
                    end else begin
                        cnt_q <= '0;
                        lvl_q <= pwm_cmd[0];
                    end
                end
                FS_FLOAT: begin
                    if (!in_float) begin
                        lvl_q <= pwm_cmd[0];
                        if (cnt_inc == CW'(EXIT_CYC)) begin
                            fs_q  <= FS_TRACK;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_inc;
                        end
                    end else begin
                        cnt_q <= '0;
                    end
                end
                default: fs_q <= FS_FLOAT;
            endcase
        end
    end

    always_comb flt_q = (fs_q == FS_FLOAT);

    // R5
    float_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_q) |-> $past(pwm_cmd[1]));

    // R7
    exit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flt_q) |-> !$past(pwm_cmd[1]));

    // R6
    level_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_cmd[1] |=> (lvl_q == $past(lvl_q)));

endmodule

// File: rtl/bgs_seq_fsm.sv
module bgs_seq_fsm
    import buck_gate_pkg::*;
#(
    parameter int DT_HS_CYC  = 15,
    parameter int DT_LS_CYC  = 13,
    parameter int MIN_ON_CYC = 350
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       flt,
    input  logic [1:0] mode_sel,
    input  logic       zc_flag,
    input  logic       uv_flag,
    output logic       hs_on,
    output logic       ls_on
);
    localparam int CM0  = (DT_HS_CYC > DT_LS_CYC) ? DT_HS_CYC : DT_LS_CYC;
    localparam int CMAX = (CM0 > MIN_ON_CYC) ? CM0 : MIN_ON_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    gate_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          halt, is_dcm, is_ccm, min_done;

    assign is_dcm   = (mode_sel == MD_DCM);
    assign is_ccm   = (mode_sel == MD_CCM);
    assign halt     = uv_flag | flt | !(is_dcm | is_ccm);
    assign min_done = (cnt_q >= CW'(MIN_ON_CYC - 1));

    always_comb begin
        st_d  = st_q;
        cnt_d = '0;
        if (halt) begin
            st_d = GS_OFF;
        end else begin
            unique case (st_q)
                GS_OFF: begin
                    if (lvl)         st_d = GS_DT_HS;
                    else if (is_dcm) st_d = GS_LS_IDLE;
                    else             st_d = GS_DT_LS;
                end
                GS_DT_HS: begin
                    if (!lvl)                           st_d = GS_DT_LS;
                    else if (cnt_q == CW'(DT_HS_CYC-1)) st_d = GS_HS;
                    else                                cnt_d = cnt_q + 1'b1;
                end
                GS_HS: begin
                    if (!lvl) st_d = GS_DT_LS;
                end
                GS_DT_LS: begin
                    if (lvl)                            st_d = GS_DT_HS;
                    else if (cnt_q == CW'(DT_LS_CYC-1)) st_d = GS_LS;
                    else                                cnt_d = cnt_q + 1'b1;
                end
                GS_LS: begin
                    if (lvl)                               st_d = GS_DT_HS;
                    else if (is_dcm && min_done && zc_flag) st_d = GS_LS_IDLE;
                    else cnt_d = min_done ? cnt_q : cnt_q + 1'b1;
                end
                GS_LS_IDLE: begin
                    if (lvl)          st_d = GS_DT_HS;
                    else if (!is_dcm) st_d = GS_DT_LS;
                end
                default: st_d = GS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= GS_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        hs_on = (st_q == GS_HS);
        ls_on = (st_q == GS_LS);
    end

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    // R4
    ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> !$past(hs_on));

    // R4
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> !$past(ls_on));

    // R11
    uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (!hs_on && !ls_on));

    // R12
    sd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_dcm || is_ccm) |=> (!hs_on && !ls_on));

    // R8
    min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on && !min_done && !halt && !lvl) |=> ls_on);

    // R10
    ccm_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on && is_ccm && !halt && !lvl) |=> ls_on);

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
    parameter int HOLD_CYC   = 150,
    parameter int EXIT_CYC   = 45,
    parameter int DT_HS_CYC  = 15,
    parameter int DT_LS_CYC  = 13,
    parameter int MIN_ON_CYC = 350
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_cmd,
    input  logic [1:0] mode_sel,
    input  logic       zc_flag,
    input  logic       uv_flag,
    output logic       hs_on,
    output logic       ls_on
);
    logic lvl_w, flt_w;

    bgs_float_filter #(
        .HOLD_CYC (HOLD_CYC),
        .EXIT_CYC (EXIT_CYC)
    ) filt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_cmd (pwm_cmd),
        .lvl_q   (lvl_w),
        .flt_q   (flt_w)
    );

    bgs_seq_fsm #(
        .DT_HS_CYC  (DT_HS_CYC),
        .DT_LS_CYC  (DT_LS_CYC),
        .MIN_ON_CYC (MIN_ON_CYC)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_w),
        .flt      (flt_w),
        .mode_sel (mode_sel),
        .zc_flag  (zc_flag),
        .uv_flag  (uv_flag),
        .hs_on    (hs_on),
        .ls_on    (ls_on)
    );

endmodule

// File: tb/buck_gate_seq_tb_top.sv
module buck_gate_seq_tb_top;
    localparam int HOLD  = 6;
    localparam int EXIT  = 3;
    localparam int DTH   = 2;
    localparam int DTL   = 3;
    localparam int MINON = 5;

    localparam logic [1:0] P_LO = 2'b00, P_HI = 2'b01, P_FL = 2'b10;
    localparam logic [1:0] M_SD = 2'b00, M_CCM = 2'b01, M_DCM = 2'b10, M_SD2 = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] pwm_cmd = P_FL;
    logic [1:0] mode_sel = M_CCM;
    logic zc_flag = 1'b0;
    logic uv_flag = 1'b0;
    logic hs_on, ls_on;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    buck_gate_seq #(
        .HOLD_CYC(HOLD), .EXIT_CYC(EXIT), .DT_HS_CYC(DTH),
        .DT_LS_CYC(DTL), .MIN_ON_CYC(MINON)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .mode_sel(mode_sel),
        .zc_flag(zc_flag), .uv_flag(uv_flag), .hs_on(hs_on), .ls_on(ls_on)
    );

    task automatic chk(input string req, input logic hs_e, input logic ls_e);
        n_chk++;
        if (hs_on !== hs_e || ls_on !== ls_e) begin
            n_fail++;
            $display("FAIL %s t=%0t hs/ls actual %b%b expected %b%b",
                     req, $time, hs_on, ls_on, hs_e, ls_e);
        end
    endtask

    task automatic wait_chk(input int n, input logic hs_e, input logic ls_e, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, hs_e, ls_e);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        pwm_cmd = P_HI;
        wait_chk(EXIT + DTH, 1'b0, 1'b0, "R1");
        wait_chk(3, 1'b1, 1'b0, "R2");

        // R3 / R4: high to low in continuous mode
        pwm_cmd = P_LO;
        wait_chk(1, 1'b1, 1'b0, "R4");
        wait_chk(DTL, 1'b0, 1'b0, "R4");
        wait_chk(3, 1'b0, 1'b1, "R3");

        // R4: low to high
        pwm_cmd = P_HI;
        wait_chk(1, 1'b0, 1'b1, "R4");
        wait_chk(DTH, 1'b0, 1'b0, "R4");
        wait_chk(3, 1'b1, 1'b0, "R2");

        // R6: sweep glitch length below the hold-off
        for (int len = 1; len < HOLD; len++) begin
            pwm_cmd = P_FL;
            wait_chk(len, 1'b1, 1'b0, "R6");
            pwm_cmd = P_HI;
            wait_chk(2, 1'b1, 1'b0, "R6");
        end

        // R5: floating held through the hold-off
        pwm_cmd = P_FL;
        wait_chk(HOLD, 1'b1, 1'b0, "R5");
        wait_chk(4, 1'b0, 1'b0, "R5");

        // R7: exit with low in continuous mode
        pwm_cmd = P_LO;
        wait_chk(EXIT + DTL, 1'b0, 1'b0, "R7");
        wait_chk(3, 1'b0, 1'b1, "R7");

        // R10: zero current ignored in continuous mode
        zc_flag = 1'b1;
        wait_chk(MINON + 3, 1'b0, 1'b1, "R10");
        zc_flag = 1'b0;

        // R8 / R9: sweep zero-current arrival over the minimum on-time
        for (int t = 0; t <= MINON + 1; t++) begin
            int n_on;
            n_on = (t + 1 > MINON) ? t + 1 : MINON;
            pwm_cmd = P_HI;
            mode_sel = M_DCM;
            zc_flag = 1'b0;
            repeat (1 + DTH) @(negedge clk);
            wait_chk(2, 1'b1, 1'b0, "R2");
            pwm_cmd = P_LO;
            wait_chk(1, 1'b1, 1'b0, "R4");
            wait_chk(DTL, 1'b0, 1'b0, "R4");
            for (int c = 0; c < n_on + 3; c++) begin
                @(negedge clk);
                if (c < n_on) chk("R8", 1'b0, 1'b1);
                else          chk("R9", 1'b0, 1'b0);
                if (c == t) zc_flag = 1'b1;
            end
            zc_flag = 1'b0;
        end

        // R9: high side restarts from the zero-current rest
        pwm_cmd = P_HI;
        wait_chk(1, 1'b0, 1'b0, "R9");
        wait_chk(DTH, 1'b0, 1'b0, "R9");
        wait_chk(2, 1'b1, 1'b0, "R9");

        // R8: a short zero-current pulse inside the window is ignored
        pwm_cmd = P_LO;
        wait_chk(1, 1'b1, 1'b0, "R4");
        wait_chk(DTL, 1'b0, 1'b0, "R4");
        @(negedge clk);
        chk("R8", 1'b0, 1'b1);
        zc_flag = 1'b1;
        @(negedge clk);
        chk("R8", 1'b0, 1'b1);
        zc_flag = 1'b0;
        wait_chk(MINON + 3, 1'b0, 1'b1, "R8");

        // R12: shutdown codes
        mode_sel = M_CCM;
        pwm_cmd = P_HI;
        repeat (1 + DTH) @(negedge clk);
        wait_chk(2, 1'b1, 1'b0, "R2");
        mode_sel = M_SD;
        wait_chk(4, 1'b0, 1'b0, "R12");
        mode_sel = M_CCM;
        wait_chk(DTH, 1'b0, 1'b0, "R12");
        wait_chk(2, 1'b1, 1'b0, "R12");
        mode_sel = M_SD2;
        wait_chk(4, 1'b0, 1'b0, "R12");

        // R13: discontinuous entry with PWM low
        pwm_cmd = P_LO;
        wait_chk(2, 1'b0, 1'b0, "R12");
        mode_sel = M_DCM;
        wait_chk(5, 1'b0, 1'b0, "R13");
        pwm_cmd = P_HI;
        wait_chk(1 + DTH, 1'b0, 1'b0, "R13");
        wait_chk(2, 1'b1, 1'b0, "R13");

        // R11: undervoltage
        mode_sel = M_CCM;
        uv_flag = 1'b1;
        wait_chk(4, 1'b0, 1'b0, "R11");
        uv_flag = 1'b0;
        wait_chk(DTH, 1'b0, 1'b0, "R11");
        wait_chk(2, 1'b1, 1'b0, "R11");

        // R11: undervoltage while low side conducts
        pwm_cmd = P_LO;
        wait_chk(1, 1'b1, 1'b0, "R4");
        wait_chk(DTL, 1'b0, 1'b0, "R4");
        wait_chk(2, 1'b0, 1'b1, "R3");
        uv_flag = 1'b1;
        wait_chk(3, 1'b0, 1'b0, "R11");
        uv_flag = 1'b0;
        wait_chk(DTL, 1'b0, 1'b0, "R11");
        wait_chk(2, 1'b0, 1'b1, "R11");

        finish_run();
    end

endmodule